// File: doc/BRIEF.md
# SDRAM Controller Configuration Register Block

This block holds the software-visible configuration state of an SDRAM controller and turns the bank settings into an address decode. Software reaches it through a device-control register port that shows only two selects. Writing the first select stores an internal register offset. Reading or writing the second select then reaches the internal register at that stored offset. Each internal register applies its own write mask.

The configuration register has two bits of note. The controller-enable bit and the self-refresh bit are copied into a read-only status register when they change. Each of the four bank registers holds a base address, a size code and an enable. While the controller is enabled, those bank registers decode a physical probe address into a registered hit flag and bank index. Any nonzero value in the ECC error status drives an interrupt line. Command sequencing, refresh generation and the data path are not part of this block.

Top module: `sdram_cfg_regs`

## Requirements
- R1: Port select 0x010 is the offset register. A write stores the full 32-bit word and a read returns it. A read or write at select 0x011 reaches the internal register chosen by the stored offset. A read at any other select returns 0.
- R2: After reset the internal registers read as follows: offset 0x20 (config) 0x00800000, offset 0x30 (refresh) 0x05F00000, offset 0x34 (power management) 0x07C00000, offset 0x80 (timing) 0x00854009. The offset register, all other internal registers and ecc_irq read 0.
- R3: Each register stores the written data ANDed with its mask: config (0x20) 0xFFE00000, refresh (0x30) 0x3FF80000, timing (0x80) 0x018FC01F, ECC config (0x94) 0x00F00000, ECC error status (0x98) 0xFFF0F000, and the banks (0x40, 0x44, 0x48, 0x4C for banks 0 to 3) 0xFFDEE001.
- R4: A write to power management (0x34) keeps data bits 31:27, and the register always reads with 0x07C00000 ORed in.
- R5: The error address register (0x10) stores all 32 bits. The two error-status registers (0x00, 0x08) are write-one-to-clear: a written 1 clears the bit and a written 0 leaves it unchanged.
- R6: Status (0x24) is read-only. A write to it changes no register.
- R7: When a config write moves bit 31 from 0 to 1, status bit 31 clears. When it moves bit 31 from 1 to 0, status bit 31 sets. After every config write, status bit 30 equals config bit 30.
- R8: An offset that names no register reads as 0xFFFFFFFF, and a write to it has no effect.
- R9: A bank covers addresses from base = bits 31:23 (with the low 23 bits zero) up to, but not including, base + (4 MiB << size code). The size code is bits 19:17 and the enable is bit 0.
- R10: A bank hits only while config bit 31 and the bank's bit 0 are both set. A bank with size code 7 never hits.
- R11: When several banks contain the probe address, bank_idx gives the lowest-numbered one. On a miss, bank_hit is 0 and bank_idx is 0.
- R12: A write to ECC error status whose masked value is nonzero sets ecc_irq. A write whose masked value is zero clears it.
- R13: Read data is combinational in the cycle of the read strobe. bank_hit and bank_idx, and ecc_irq, appear one clock after their cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 for a write, 0 for a read |
| acc_sel | input | 10 | Register port select |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for the current strobe |
| probe_addr | input | 32 | Physical address to decode |
| bank_hit | output | 1 | Registered: the probe address falls in an enabled bank |
| bank_idx | output | 2 | Registered: index of the bank that hit |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
Each mask is checked by writing all ones and reading back. A design that dropped or swapped a mask would return stray bits. The config sequence steps through enable 0→1, 1→0 and self-refresh toggles, so a status bit that was not updated, or was updated with the wrong polarity, reads back wrong.

Decode probes land on the last byte of a bank and on the first byte past it, which catches off-by-one range compares. They also hit two overlapping banks, a bank with size code 7, and a bank left enabled while the controller is disabled. Wrong priority, a missing gate or a missing invalid-code check each shows up as a wrong index or a wrong hit flag.

The interrupt is driven with values that are nonzero only in bits the mask removes. A design that tested the raw data instead of the masked value would raise the interrupt there.

// File: rtl/sdcfg_pkg.sv
package sdcfg_pkg;
  localparam int DW = 32;

  // internal register offsets (held in the offset register)
  localparam logic [DW-1:0] OFF_ERRST_A = 32'h00;
  localparam logic [DW-1:0] OFF_ERRST_B = 32'h08;
  localparam logic [DW-1:0] OFF_ERRADR  = 32'h10;
  localparam logic [DW-1:0] OFF_CFG     = 32'h20;
  localparam logic [DW-1:0] OFF_STAT    = 32'h24;
  localparam logic [DW-1:0] OFF_RFSH    = 32'h30;
  localparam logic [DW-1:0] OFF_PWR     = 32'h34;
  localparam logic [DW-1:0] OFF_BANK0   = 32'h40;
  localparam int            BANK_STRIDE = 4;
  localparam logic [DW-1:0] OFF_TIME    = 32'h80;
  localparam logic [DW-1:0] OFF_ECFG    = 32'h94;
  localparam logic [DW-1:0] OFF_ESTAT   = 32'h98;

  // write masks
  localparam logic [DW-1:0] MSK_CFG   = 32'hFFE0_0000;
  localparam logic [DW-1:0] MSK_RFSH  = 32'h3FF8_0000;
  localparam logic [DW-1:0] MSK_TIME  = 32'h018F_C01F;
  localparam logic [DW-1:0] MSK_ECFG  = 32'h00F0_0000;
  localparam logic [DW-1:0] MSK_ESTAT = 32'hFFF0_F000;
  localparam logic [DW-1:0] MSK_BANK  = 32'hFFDE_E001;
  localparam logic [DW-1:0] MSK_PWR   = 32'hF800_0000;
  localparam logic [DW-1:0] PWR_FIXED = 32'h07C0_0000;

  // reset values
  localparam logic [DW-1:0] RST_CFG  = 32'h0080_0000;
  localparam logic [DW-1:0] RST_RFSH = 32'h05F0_0000;
  localparam logic [DW-1:0] RST_PWR  = 32'h07C0_0000;
  localparam logic [DW-1:0] RST_TIME = 32'h0085_4009;

  // bit positions inside config / status and bank registers
  localparam int CFG_EN_BIT  = 31;
  localparam int CFG_SR_BIT  = 30;
  localparam int BNK_BASE_LO = 23;
  localparam int BNK_SZ_LO   = 17;
  localparam int BNK_SZ_W    = 3;
  localparam int BNK_EN_BIT  = 0;
  localparam int MIN_BANK_LG = 22;   // 4 MiB
endpackage

// File: rtl/sdcfg_regfile.sv
module sdcfg_regfile
  import sdcfg_pkg::*;
#(
  parameter int SEL_W     = 10,
  parameter int NBANK     = 4,
  parameter logic [SEL_W-1:0] SEL_OFFS = 10'h010,
  parameter logic [SEL_W-1:0] SEL_DATA = 10'h011
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      acc_en,
  input  logic                      acc_wr,
  input  logic [SEL_W-1:0]          acc_sel,
  input  logic [DW-1:0]             acc_wdata,
  output logic [DW-1:0]             acc_rdata,
  output logic [DW-1:0]             cfg_o,
  output logic [DW-1:0]             status_o,
  output logic [DW-1:0]             pwr_o,
  output logic [DW-1:0]             off_o,
  output logic [NBANK-1:0][DW-1:0]  banks_o,
  output logic                      ecc_irq_o
);
  logic [DW-1:0] off_q, errst_a_q, errst_b_q, erradr_q, cfg_q, stat_q;
  logic [DW-1:0] rfsh_q, pwr_q, time_q, ecfg_q, estat_q;
  logic [NBANK-1:0][DW-1:0] bank_q;
  logic          irq_q;
  logic [NBANK-1:0] bank_sel;

  logic offs_wr, data_wr;
  logic [DW-1:0] cfg_new, estat_new;

  assign offs_wr   = acc_en && acc_wr && (acc_sel == SEL_OFFS);
  assign data_wr   = acc_en && acc_wr && (acc_sel == SEL_DATA);
  assign cfg_new   = acc_wdata & MSK_CFG;
  assign estat_new = acc_wdata & MSK_ESTAT;

  for (genvar b = 0; b < NBANK; b++) begin : g_bsel
    assign bank_sel[b] = (off_q == OFF_BANK0 + DW'(b * BANK_STRIDE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q     <= '0;
      errst_a_q <= '0;
      errst_b_q <= '0;
      erradr_q  <= '0;
      cfg_q     <= RST_CFG;
      stat_q    <= '0;
      rfsh_q    <= RST_RFSH;
      pwr_q     <= RST_PWR;
      time_q    <= RST_TIME;
      ecfg_q    <= '0;
      estat_q   <= '0;
      bank_q    <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (offs_wr) off_q <= acc_wdata;
      if (data_wr) begin
        case (off_q)
          OFF_ERRST_A: errst_a_q <= errst_a_q & ~acc_wdata;
          OFF_ERRST_B: errst_b_q <= errst_b_q & ~acc_wdata;
          OFF_ERRADR:  erradr_q  <= acc_wdata;
          OFF_CFG: begin
            cfg_q <= cfg_new;
            if (!cfg_q[CFG_EN_BIT] && cfg_new[CFG_EN_BIT])
              stat_q[CFG_EN_BIT] <= 1'b0;
            else if (cfg_q[CFG_EN_BIT] && !cfg_new[CFG_EN_BIT])
              stat_q[CFG_EN_BIT] <= 1'b1;
            stat_q[CFG_SR_BIT] <= cfg_new[CFG_SR_BIT];
          end
          OFF_RFSH:  rfsh_q <= acc_wdata & MSK_RFSH;
          OFF_PWR:   pwr_q  <= (acc_wdata & MSK_PWR) | PWR_FIXED;
          OFF_TIME:  time_q <= acc_wdata & MSK_TIME;
          OFF_ECFG:  ecfg_q <= acc_wdata & MSK_ECFG;
          OFF_ESTAT: begin
            estat_q <= estat_new;
            irq_q   <= (estat_new != '0);
          end
          default: ;
        endcase
        for (int b = 0; b < NBANK; b++) begin
          if (bank_sel[b]) bank_q[b] <= acc_wdata & MSK_BANK;
        end
      end
    end
  end

  logic [DW-1:0] data_rd;
  always_comb begin
    case (off_q)
      OFF_ERRST_A: data_rd = errst_a_q;
      OFF_ERRST_B: data_rd = errst_b_q;
      OFF_ERRADR:  data_rd = erradr_q;
      OFF_CFG:     data_rd = cfg_q;
      OFF_STAT:    data_rd = stat_q;
      OFF_RFSH:    data_rd = rfsh_q;
      OFF_PWR:     data_rd = pwr_q;
      OFF_TIME:    data_rd = time_q;
      OFF_ECFG:    data_rd = ecfg_q;
      OFF_ESTAT:   data_rd = estat_q;
      default:     data_rd = '1;
    endcase
    for (int b = 0; b < NBANK; b++) begin
      if (bank_sel[b]) data_rd = bank_q[b];
    end
  end

  always_comb begin
    if (!acc_en || acc_wr)         acc_rdata = '0;
    else if (acc_sel == SEL_OFFS)  acc_rdata = off_q;
    else if (acc_sel == SEL_DATA)  acc_rdata = data_rd;
    else                           acc_rdata = '0;
  end

  assign cfg_o     = cfg_q;
  assign status_o  = stat_q;
  assign pwr_o     = pwr_q;
  assign off_o     = off_q;
  assign banks_o   = bank_q;
  assign ecc_irq_o = irq_q;
endmodule

// File: rtl/sdcfg_bank_decode.sv
module sdcfg_bank_decode
  import sdcfg_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      glob_en,
  input  logic [NBANK-1:0][DW-1:0]  banks,
  input  logic [DW-1:0]             addr,
  output logic                      hit_o,
  output logic [IDX_W-1:0]          idx_o
);
  localparam int AW1 = DW + 1;
  localparam logic [BNK_SZ_W-1:0] SZ_BAD = '1;

  logic [NBANK-1:0] in_range;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [BNK_SZ_W-1:0] code;
    logic [AW1-1:0]      lo, span, hi, a_ext;
    logic                usable;
    assign code   = banks[b][BNK_SZ_LO +: BNK_SZ_W];
    assign lo     = {1'b0, banks[b][DW-1:BNK_BASE_LO], {BNK_BASE_LO{1'b0}}};
    assign span   = AW1'(1) << (MIN_BANK_LG + int'(code));
    assign hi     = lo + span;
    assign a_ext  = {1'b0, addr};
    assign usable = glob_en && banks[b][BNK_EN_BIT] && (code != SZ_BAD);
    assign in_range[b] = usable && (a_ext >= lo) && (a_ext < hi);
  end

  logic             hit_d;
  logic [IDX_W-1:0] idx_d;
  always_comb begin
    hit_d = 1'b0;
    idx_d = '0;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (in_range[b]) begin
        hit_d = 1'b1;
        idx_d = IDX_W'(b);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o <= 1'b0;
      idx_o <= '0;
    end else begin
      hit_o <= hit_d;
      idx_o <= idx_d;
    end
  end
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdcfg_pkg::*;
#(
  parameter int SEL_W = 10,
  parameter int NBANK = 4,
  parameter int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  parameter logic [SEL_W-1:0] SEL_OFFS = 10'h010,
  parameter logic [SEL_W-1:0] SEL_DATA = 10'h011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic [DW-1:0]     acc_wdata,
  output logic [DW-1:0]     acc_rdata,
  input  logic [DW-1:0]     probe_addr,
  output logic              bank_hit,
  output logic [IDX_W-1:0]  bank_idx,
  output logic              ecc_irq
);
  logic [DW-1:0]            rf_cfg, rf_status, rf_pwr, rf_off;
  logic [NBANK-1:0][DW-1:0] rf_banks;

  sdcfg_regfile #(
    .SEL_W(SEL_W), .NBANK(NBANK), .SEL_OFFS(SEL_OFFS), .SEL_DATA(SEL_DATA)
  ) u_rf (
    .clk(clk), .rst(rst),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_sel(acc_sel),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .cfg_o(rf_cfg), .status_o(rf_status), .pwr_o(rf_pwr), .off_o(rf_off),
    .banks_o(rf_banks), .ecc_irq_o(ecc_irq)
  );

  sdcfg_bank_decode #(.NBANK(NBANK), .IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst(rst),
    .glob_en(rf_cfg[CFG_EN_BIT]),
    .banks(rf_banks),
    .addr(probe_addr),
    .hit_o(bank_hit),
    .idx_o(bank_idx)
  );
endmodule

// File: rtl/sdcfg_checker.sv
module sdcfg_checker
  import sdcfg_pkg::*;
#(
  parameter int SEL_W = 10,
  parameter logic [SEL_W-1:0] SEL_DATA = 10'h011
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_en,
  input logic             acc_wr,
  input logic [SEL_W-1:0] acc_sel,
  input logic [DW-1:0]    acc_wdata,
  input logic [DW-1:0]    cur_off,
  input logic [DW-1:0]    cfg,
  input logic [DW-1:0]    status,
  input logic [DW-1:0]    pwr,
  input logic             ecc_irq,
  input logic             bank_hit
);
  logic dwr;
  assign dwr = acc_en && acc_wr && (acc_sel == SEL_DATA);

  AST_STATUS_RO: assert property (@(posedge clk) disable iff (rst)
    (dwr && cur_off == OFF_STAT) |=> $stable(status)); // R6

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    (dwr && cur_off == OFF_ESTAT && (acc_wdata & MSK_ESTAT) != '0) |=> ecc_irq); // R12

  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
    (dwr && cur_off == OFF_ESTAT && (acc_wdata & MSK_ESTAT) == '0) |=> !ecc_irq); // R12

  AST_DEC_GATED: assert property (@(posedge clk) disable iff (rst)
    !cfg[CFG_EN_BIT] |=> !bank_hit); // R10

  AST_PWR_FIXED: assert property (@(posedge clk) disable iff (rst)
    (pwr & PWR_FIXED) == PWR_FIXED); // R4

  AST_EN_STATUS: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg[CFG_EN_BIT]) |-> !status[CFG_EN_BIT]); // R7

  AST_DIS_STATUS: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg[CFG_EN_BIT]) |-> status[CFG_EN_BIT]); // R7
endmodule

bind sdram_cfg_regs sdcfg_checker #(.SEL_W(SEL_W), .SEL_DATA(SEL_DATA)) u_chk (
  .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_sel(acc_sel),
  .acc_wdata(acc_wdata), .cur_off(rf_off), .cfg(rf_cfg), .status(rf_status),
  .pwr(rf_pwr), .ecc_irq(ecc_irq), .bank_hit(bank_hit)
);

// File: tb/tb_sdram_cfg_regs.sv
`timescale 1ns/1ps
module tb_sdram_cfg_regs;
  localparam logic [9:0] P_OFF = 10'h010;
  localparam logic [9:0] P_DAT = 10'h011;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0, acc_wr = 1'b0;
  logic [9:0]  acc_sel = '0;
  logic [31:0] acc_wdata = '0, probe_addr = '0;
  logic [31:0] acc_rdata;
  logic        bank_hit, ecc_irq;
  logic [1:0]  bank_idx;

  always #2.5 clk = ~clk;

  sdram_cfg_regs dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_sel(acc_sel),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .probe_addr(probe_addr),
    .bank_hit(bank_hit), .bank_idx(bank_idx), .ecc_irq(ecc_irq)
  );

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  int vectors = 0, miscmp = 0;
  logic mon_on = 1'b0;

  // monitor: pops one expected item per flagged cycle, mid-cycle
  always @(negedge clk) begin
    if (mon_on) begin
      item_t it;
      logic [31:0] act;
      if (sb.size() == 0) begin
        miscmp++;
        $display("FAIL monitor: no expected item, got none expected one");
      end else begin
        it = sb.pop_front();
        case (it.kind)
          0: act = acc_rdata;
          1: act = {29'b0, bank_hit, bank_idx};
          default: act = {31'b0, ecc_irq};
        endcase
        vectors++;
        if (act !== it.exp) begin
          miscmp++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_now(int kind, logic [31:0] e, string tag);
    sb.push_back('{kind, e, tag});
    mon_on = 1'b1;
    @(posedge clk); #1;
    mon_on = 1'b0;
  endtask

  task automatic wr_port(logic [9:0] s, logic [31:0] d);
    acc_en = 1'b1; acc_wr = 1'b1; acc_sel = s; acc_wdata = d;
    @(posedge clk); #1;
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd_port(logic [9:0] s, logic [31:0] e, string tag);
    acc_en = 1'b1; acc_wr = 1'b0; acc_sel = s;
    expect_now(0, e, tag);
    acc_en = 1'b0;
  endtask

  task automatic iwr(logic [31:0] off, logic [31:0] d);
    wr_port(P_OFF, off);
    wr_port(P_DAT, d);
  endtask

  task automatic ird(logic [31:0] off, logic [31:0] e, string tag);
    wr_port(P_OFF, off);
    rd_port(P_DAT, e, tag);
  endtask

  task automatic dec_chk(logic [31:0] a, logic h, logic [1:0] i, string tag);
    probe_addr = a;
    @(posedge clk); #1;
    expect_now(1, {29'b0, h, i}, tag);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R2 reset state
    rd_port(P_OFF, 32'h0, "R2 offset reg");
    expect_now(2, 32'h0, "R2 irq low");
    ird(32'h20, 32'h0080_0000, "R2 config");
    ird(32'h24, 32'h0, "R2 status");
    ird(32'h30, 32'h05F0_0000, "R2 refresh");
    ird(32'h34, 32'h07C0_0000, "R2 power");
    ird(32'h80, 32'h0085_4009, "R2 timing");
    ird(32'h94, 32'h0, "R2 ecc cfg");
    ird(32'h98, 32'h0, "R2 ecc status");
    ird(32'h4C, 32'h0, "R2 bank3");

    // R1 indirect access
    wr_port(P_OFF, 32'hDEAD_0030);
    rd_port(P_OFF, 32'hDEAD_0030, "R1 offset readback");
    rd_port(10'h012, 32'h0, "R1 foreign select");
    ird(32'h10, 32'h0, "R1 data port read");

    // R3 masks
    iwr(32'h30, 32'hFFFF_FFFF); ird(32'h30, 32'h3FF8_0000, "R3 refresh mask");
    iwr(32'h80, 32'hFFFF_FFFF); ird(32'h80, 32'h018F_C01F, "R3 timing mask");
    iwr(32'h94, 32'hFFFF_FFFF); ird(32'h94, 32'h00F0_0000, "R3 ecc cfg mask");
    iwr(32'h40, 32'hFFFF_FFFF); ird(32'h40, 32'hFFDE_E001, "R3 bank mask");

    // R4 power management
    iwr(32'h34, 32'hFFFF_FFFF); ird(32'h34, 32'hFFC0_0000, "R4 power ones");
    iwr(32'h34, 32'h0);         ird(32'h34, 32'h07C0_0000, "R4 power zero");

    // R5 error address / error status
    iwr(32'h10, 32'h1234_5678); ird(32'h10, 32'h1234_5678, "R5 err addr");
    iwr(32'h00, 32'hFFFF_FFFF); ird(32'h00, 32'h0, "R5 err status A");
    iwr(32'h08, 32'hFFFF_FFFF); ird(32'h08, 32'h0, "R5 err status B");

    // R7 status mirroring; R3 config mask
    iwr(32'h20, 32'hFFFF_FFFF); ird(32'h20, 32'hFFE0_0000, "R3 config mask");
    ird(32'h24, 32'h4000_0000, "R7 enable+selfrefresh");
    iwr(32'h20, 32'h0);         ird(32'h24, 32'h8000_0000, "R7 disable");
    iwr(32'h20, 32'hC000_0000); ird(32'h24, 32'h4000_0000, "R7 re-enable");
    iwr(32'h20, 32'h8000_0000); ird(32'h24, 32'h0, "R7 selfrefresh off");
    iwr(32'h20, 32'h0);         ird(32'h24, 32'h8000_0000, "R7 disable again");

    // R6 status read-only
    iwr(32'h24, 32'h0);         ird(32'h24, 32'h8000_0000, "R6 status write ignored");
    ird(32'h20, 32'h0, "R6 config untouched");

    // R8 unknown offset
    ird(32'h04, 32'hFFFF_FFFF, "R8 unknown reads ones");
    iwr(32'h04, 32'hAAAA_AAAA); ird(32'h10, 32'h1234_5678, "R8 unknown write no effect");

    // R9 R10 R11 decode
    iwr(32'h40, 32'h0004_0001);   // bank0: base 0, 16 MiB
    iwr(32'h44, 32'h0100_0001);   // bank1: base 16M, 4 MiB
    iwr(32'h48, 32'h0080_0001);   // bank2: base 8M, 4 MiB, overlaps bank0
    iwr(32'h4C, 32'h100E_0001);   // bank3: invalid size code 7
    dec_chk(32'h0100_0000, 1'b0, 2'd0, "R10 controller disabled");
    iwr(32'h20, 32'h8000_0000);
    dec_chk(32'h00FF_FFFF, 1'b1, 2'd0, "R9 bank0 last byte");
    dec_chk(32'h0100_0000, 1'b1, 2'd1, "R9 bank1 first byte");
    dec_chk(32'h013F_FFFF, 1'b1, 2'd1, "R9 bank1 last byte");
    dec_chk(32'h0140_0000, 1'b0, 2'd0, "R9 past bank1");
    dec_chk(32'h0090_0000, 1'b1, 2'd0, "R11 overlap lowest");
    dec_chk(32'h1000_0000, 1'b0, 2'd0, "R10 invalid code");
    iwr(32'h40, 32'h0004_0000);
    dec_chk(32'h0090_0000, 1'b1, 2'd2, "R10 bank0 disabled");
    iwr(32'h20, 32'h0);
    dec_chk(32'h0090_0000, 1'b0, 2'd0, "R10 global disable");

    // R12 R13 ecc interrupt
    iwr(32'h98, 32'h0000_0FFF); expect_now(2, 32'h0, "R12 masked-out bits");
    iwr(32'h98, 32'h0000_F000); expect_now(2, 32'h1, "R12 rise");
    ird(32'h98, 32'h0000_F000, "R12 ecc status");
    iwr(32'h98, 32'hFFFF_FFFF); expect_now(2, 32'h1, "R12 stays high");
    ird(32'h98, 32'hFFF0_F000, "R3 ecc status mask");
    iwr(32'h98, 32'h0);         expect_now(2, 32'h0, "R12 fall");

    repeat (2) @(posedge clk);
    if (sb.size() != 0) begin
      miscmp++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    finish_run();
  end
endmodule